// File: doc/BRIEF.md
# Signed Six-Operand Compressor Tree Adder

This block adds six signed two's-complement operands of four bits each and returns their exact signed sum on seven bits. The operands are split into groups of at most four; every operand inside a group is sign-extended only as far as that group's size demands. The first reduction level reduces each group column by column, with 4:2 compressor cells for groups of three or four and 2-input adder cells for groups of two. Each group is then resolved to an exact group total. The second level reduces the group totals in the same way, and a carry-propagate adder forms the final sum.

The data path is a stream. A word is accepted when `in_valid` and `in_ready` are both high at a rising clock edge. With pipelining enabled, a register stage follows each reduction level. All stages advance together whenever the output slot is empty or is being taken. When `out_valid` is high and `out_ready` is low, the whole pipeline freezes and `in_ready` drops. An upstream source must hold its word until it is accepted.

Top module: `sgn_ctree`

## Requirements
- R1: With operand k in bits [4k+3:4k] of `in_ops`, read as a 4-bit two's-complement value, `out_sum` read as a 7-bit two's-complement value equals the sum of all six operands, for every operand combination.
- R2: All six operands at -8 (4'h8) give -48, and all six at +7 (4'h7) give +42, with no wrap-around.
- R3: The first group (operands 0 to 3) and the second group (operands 4 and 5) are each resolved exactly: 6 bits for the group of four, 5 bits for the group of two. A pattern with one group at its minimum and the other at its maximum still yields the exact total.
- R4: With pipelining on and `out_ready` high, a word accepted at clock edge t appears with `out_valid` high after edge t+1 and not earlier.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_sum` holds its value at the next edge. `in_ready` equals `out_ready` OR NOT `out_valid`.
- R6: After reset, `out_valid` is low and `in_ready` is high.
- R7: Under random input gaps and random output stalls, every accepted word produces exactly one result, in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand word present |
| in_ready | output | 1 | Block can take a word this cycle |
| in_ops | input | 24 | Six packed 4-bit signed operands, operand 0 in the low nibble |
| out_valid | output | 1 | Sum present on `out_sum` |
| out_ready | input | 1 | Downstream takes the sum this cycle |
| out_sum | output | 7 | Signed sum of the six operands |

## Verification
A wrong compressor cell, carry hookup or sign-extension width shows as a wrong `out_sum`. This error appears two cycles after the offending word is accepted, and only for operand patterns that exercise the faulty column or carry, so the bench sweeps every value of four operands against varying values of the other two. A wrong valid or stall register shows as a lost, duplicated or reordered result. It can also show as a result that changes while it is held, which becomes visible in the first stalled cycle. The bench therefore compares each result with an in-order queue of expected totals while it throttles both sides at random.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int GRP_MAX = 4;

  // number of operands that fall into group g
  function automatic int grp_size(input int n_ops, input int g);
    int rem;
    rem = n_ops - g * GRP_MAX;
    return (rem > GRP_MAX) ? GRP_MAX : rem;
  endfunction

  // extra sign bits a group of this size needs to hold its total
  function automatic int grp_ext(input int sz);
    if (sz <= 1) return 0;
    else if (sz == 2) return 1;
    else return 2;
  endfunction
endpackage

// File: rtl/ct_c42.sv
module ct_c42 (
  input  logic x0,
  input  logic x1,
  input  logic x2,
  input  logic x3,
  input  logic cin,
  output logic sum,
  output logic carry,
  output logic cout
);
  logic s1;
  // first full adder: its carry leaves sideways to the next column
  assign s1    = x0 ^ x1 ^ x2;
  assign cout  = (x0 & x1) | (x0 & x2) | (x1 & x2);
  // second full adder absorbs the fourth bit and the incoming side carry
  assign sum   = s1 ^ x3 ^ cin;
  assign carry = (s1 & x3) | (s1 & cin) | (x3 & cin);
endmodule

// File: rtl/ct_row.sv
module ct_row #(
  parameter int W = 6,
  parameter int N = 4
) (
  input  logic [3:0][W-1:0] vin,
  output logic [W-1:0]      s,
  output logic [W-1:0]      c
);
  // s + c equals the sum of the first N rows of vin, modulo 2**W
  generate
    if (N >= 3) begin : g_c42
      logic [W-1:0] cw;
      logic [W:0]   hc;
      logic         drop_unused;
      assign hc[0] = 1'b0;
      for (genvar i = 0; i < W; i++) begin : g_col
        ct_c42 u_cell (
          .x0(vin[0][i]), .x1(vin[1][i]), .x2(vin[2][i]), .x3(vin[3][i]),
          .cin(hc[i]), .sum(s[i]), .carry(cw[i]), .cout(hc[i+1])
        );
      end
      assign c = {cw[W-2:0], 1'b0};
      assign drop_unused = ^{cw[W-1], hc[W]};
    end else if (N == 2) begin : g_add2
      logic [W-1:0] gw;
      logic         drop_unused;
      for (genvar i = 0; i < W; i++) begin : g_col
        assign s[i]  = vin[0][i] ^ vin[1][i];
        assign gw[i] = vin[0][i] & vin[1][i];
      end
      assign c = {gw[W-2:0], 1'b0};
      assign drop_unused = ^{gw[W-1], vin[2], vin[3]};
    end else begin : g_pass
      logic drop_unused;
      assign s = vin[0];
      assign c = '0;
      assign drop_unused = ^{vin[1], vin[2], vin[3]};
    end
  endgenerate
endmodule

// File: rtl/sgn_ctree.sv
module sgn_ctree #(
  parameter int NUM_OPS = 6,
  parameter int OP_W    = 4,
  parameter bit PIPE    = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [NUM_OPS*OP_W-1:0]   in_ops,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [OP_W+$clog2(NUM_OPS)-1:0] out_sum
);
  import ct_pkg::*;

  localparam int NG    = (NUM_OPS + GRP_MAX - 1) / GRP_MAX;
  localparam int SUM_W = OP_W + $clog2(NUM_OPS);

  logic [NG-1:0][SUM_W-1:0] gsum_d, gsum_q;
  logic [3:0][SUM_W-1:0]    l2in;
  logic [SUM_W-1:0]         s2_d, c2_d, s2_q, c2_q, l2ref;
  logic                     v1, v2;

  // ---------------- level 1: per-group reduction ----------------
  generate
    for (genvar g = 0; g < NG; g++) begin : g_grp
      localparam int SZ = grp_size(NUM_OPS, g);
      localparam int GW = OP_W + grp_ext(SZ);
      logic [3:0][GW-1:0] gin;
      logic [GW-1:0]      rs, rc, gx;
      int                 gref;

      for (genvar j = 0; j < 4; j++) begin : g_in
        if (j < SZ) begin : g_use
          assign gin[j] = GW'($signed(in_ops[(g*GRP_MAX+j)*OP_W +: OP_W]));
        end else begin : g_zero
          assign gin[j] = '0;
        end
      end

      ct_row #(.W(GW), .N(SZ)) u_row (.vin(gin), .s(rs), .c(rc));

      assign gx        = rs + rc;
      assign gsum_d[g] = SUM_W'($signed(gx));

      always_comb begin
        gref = 0;
        for (int j = 0; j < SZ; j++)
          gref += int'($signed(in_ops[(g*GRP_MAX+j)*OP_W +: OP_W]));
      end

      // R3: the narrow group width never loses the group total
      a_r3_group_exact: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ($signed(gx) == gref));
    end
  endgenerate

  // ---------------- level 2: combine the group totals ----------------
  generate
    for (genvar j = 0; j < 4; j++) begin : g_l2
      if (j < NG) begin : g_use
        assign l2in[j] = gsum_q[j];
      end else begin : g_zero
        assign l2in[j] = '0;
      end
    end
  endgenerate

  ct_row #(.W(SUM_W), .N(NG)) u_l2 (.vin(l2in), .s(s2_d), .c(c2_d));

  assign l2ref = l2in[0] + l2in[1] + l2in[2] + l2in[3];

  // R1: second level keeps the total of its inputs
  a_r1_level2_sum: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |-> ((s2_d + c2_d) == l2ref));

  // ---------------- stage registers and handshake ----------------
  generate
    if (PIPE) begin : g_pipe
      logic adv;
      assign adv      = out_ready | ~v2;
      assign in_ready = adv;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v1     <= 1'b0;
          v2     <= 1'b0;
          gsum_q <= '0;
          s2_q   <= '0;
          c2_q   <= '0;
        end else if (adv) begin
          v1     <= in_valid;
          gsum_q <= gsum_d;
          v2     <= v1;
          s2_q   <= s2_d;
          c2_q   <= c2_d;
        end
      end

      // R5: a refused result is held unchanged
      a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sum)));

      // R6: pipeline comes out of reset empty
      a_r6_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !out_valid);
    end else begin : g_comb
      assign in_ready = out_ready;
      assign v1       = in_valid;
      assign v2       = in_valid;
      assign gsum_q   = gsum_d;
      assign s2_q     = s2_d;
      assign c2_q     = c2_d;
    end
  endgenerate

  // final carry-propagate adder
  assign out_sum   = s2_q + c2_q;
  assign out_valid = v2;
endmodule

// File: tb/sim_sgn_ctree.sv
module sim_sgn_ctree;
  localparam int CLK_PERIOD = 10;
  localparam int SWEEP_END  = 4 + 65536;
  localparam int NITEMS     = SWEEP_END + 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_ops = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [6:0]  out_sum;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  int expq [0:15];
  int tagq [0:15];
  int wr = 0;
  int rd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sgn_ctree u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ops(in_ops), .out_valid(out_valid), .out_ready(out_ready),
    .out_sum(out_sum)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int opsum(input logic [23:0] v);
    int s = 0;
    for (int k = 0; k < 6; k++) s += int'($signed(v[k*4 +: 4]));
    return s;
  endfunction

  function automatic logic [23:0] mk(input int n);
    int m;
    logic [3:0] a4, a5;
    if (n == 0) return {6{4'h8}};
    if (n == 1) return {6{4'h7}};
    if (n == 2) return {4'h7, 4'h7, 4'h8, 4'h8, 4'h8, 4'h8};
    if (n == 3) return {4'h8, 4'h8, 4'h7, 4'h7, 4'h7, 4'h7};
    m  = n - 4;
    a4 = 4'((m * 5) & 15);
    a5 = 4'(((m >> 4) + (m >> 12) + 3) & 15);
    return {a5, a4, 16'(m)};
  endfunction

  function automatic string tagname(input int t);
    case (t)
      2: return "R2";
      3: return "R3";
      7: return "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    int  n;
    bit  pend;
    bit  hold_chk;
    int  held;
    bit  stall;
    int  t;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R6: empty after reset
    check(out_valid == 1'b0, "R6 out_valid", int'(out_valid), 0);
    check(in_ready == 1'b1, "R6 in_ready", int'(in_ready), 1);

    // R4: latency of one word, operands 1..6 sum to 21
    @(negedge clk);
    out_ready = 1'b1;
    in_valid  = 1'b1;
    in_ops    = {4'd6, 4'd5, 4'd4, 4'd3, 4'd2, 4'd1};
    #1;
    check(in_ready == 1'b1, "R4 accept", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(out_valid == 1'b0, "R4 not early", int'(out_valid), 0);
    @(negedge clk);
    #1;
    check(out_valid == 1'b1, "R4 valid", int'(out_valid), 1);
    check(int'($signed(out_sum)) == 21, "R4 sum", int'($signed(out_sum)), 21);

    n = 0;
    pend = 1'b0;
    hold_chk = 1'b0;
    held = 0;
    while (n < NITEMS || rd != wr) begin
      @(negedge clk);
      if (hold_chk) begin
        check(out_valid == 1'b1, "R5 valid held", int'(out_valid), 1);
        check(int'($signed(out_sum)) == held, "R5 sum held", int'($signed(out_sum)), held);
      end
      stall = (n >= SWEEP_END);
      out_ready = stall ? 1'($urandom % 2) : 1'b1;
      if (!pend) begin
        if (n < NITEMS && (!stall || ($urandom % 10) < 7)) begin
          in_ops   = mk(n);
          in_valid = 1'b1;
          pend     = 1'b1;
        end else begin
          in_valid = 1'b0;
        end
      end
      #1;
      if (stall)
        check(in_ready == (out_ready || !out_valid), "R5 ready rule",
              int'(in_ready), int'(out_ready || !out_valid));
      if (out_valid && out_ready) begin
        if (rd == wr) begin
          check(1'b0, "R7 extra result", int'($signed(out_sum)), 0);
        end else begin
          check(int'($signed(out_sum)) == expq[rd % 16], tagname(tagq[rd % 16]),
                int'($signed(out_sum)), expq[rd % 16]);
          rd++;
        end
      end
      if (in_valid && in_ready) begin
        if (n < 2) t = 2;
        else if (n < 4) t = 3;
        else if (n < SWEEP_END) t = 1;
        else t = 7;
        expq[wr % 16] = opsum(in_ops);
        tagq[wr % 16] = t;
        wr++;
        n++;
        pend = 1'b0;
      end
      hold_chk = out_valid && !out_ready;
      held     = int'($signed(out_sum));
    end
    check(rd == NITEMS, "R7 count", rd, NITEMS);
    finish_run();
  end
endmodule